// File: doc/BRIEF.md
# Dual-Slope PWM Timer with Clock Divider

An 8-bit synchronous timer that advances only on single-cycle enable pulses from a selectable clock divider (1, 8, 64, 256 or 1024). It has two counting modes. The wrap mode counts upward and rolls over from 255 to 0. The dual-slope mode climbs from 0 to 255 and then descends back to 0, which gives a 510-tick period. In dual-slope mode a compare register sets the level of a PWM pin. The pin's polarity can be selected, and the output stays constant when the compare value sits at either end of the range.

Two sticky flags report events. One marks the end of a counting cycle (a rollover, or arrival at zero). The other marks the counter reaching the compare value. Each flag has its own clear strobe. The intended use is motor or LED drive: software selects the divider, the mode and the polarity, then writes duty values while the timer runs. In dual-slope mode a new duty value is held back until the turning point at the top of the count, so a write never produces a partial pulse.

Top module: `pwmt_timer`

## Requirements
- R1: The count changes only on cycles where the divider enable is high. Divider select codes 0, 1, 2, 3 and 4 give ratios of 1, 8, 64, 256 and 1024, and codes 5 to 7 also give 1024. The divider restarts at reset, so the first advance comes N cycles after reset is released, and every count value then holds for exactly N cycles.
- R2: With mode input 0 (wrap), each enabled tick adds one to the count, and 255 is followed by 0.
- R3: In wrap mode the end-of-cycle flag becomes 1 on the same clock edge on which the count goes from 255 to 0.
- R4: With mode input 1 (dual-slope), the count rises one step per tick from 0 to 255, falls one step per tick back to 0, and then rises again. A full period is 510 ticks.
- R5: In dual-slope mode the end-of-cycle flag becomes 1 on the edge on which the falling count reaches 0.
- R6: The match flag becomes 1 on the edge on which a tick moves the count onto the compare value in effect after that edge.
- R7: Each flag stays at 1 until its own clear strobe is sampled high. If a flag's set event and its clear strobe fall in the same cycle, the flag ends up at 1.
- R8: In dual-slope mode with the polarity input at 0 and a compare value C strictly between 0 and 255, the pin is 1 exactly while the count is below C on the rising slope (including the values 0 and 255), or at most C on the falling slope. The pin therefore drops at the upward match and rises at the downward match.
- R9: In dual-slope mode with the polarity input at 0, a compare value of 0 holds the pin at 0 for the whole period, and a compare value of 255 holds it at 1 for the whole period.
- R10: In dual-slope mode with the polarity input at 1, the pin is the complement of the R8 and R9 level in every case, including both extreme compare values.
- R11: In dual-slope mode a written compare value is buffered and takes effect on the tick on which the count reaches 255. In wrap mode a write takes effect on the next edge.
- R12: In wrap mode the pin is 0, whatever the polarity input.
- R13: While reset is high and just after it is released, the count is 0, both flags are 0, the held compare value is 0, and the pin equals the polarity input in dual-slope mode and 0 in wrap mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps_sel_i | input | 3 | Divider select code |
| mode_i | input | 1 | 0 = wrap counting, 1 = dual-slope counting |
| inv_i | input | 1 | 1 = inverted pin polarity |
| cmp_wr_i | input | 1 | Compare value write strobe |
| cmp_data_i | input | 8 | Compare value to write |
| clr_ovf_i | input | 1 | Clear strobe for the end-of-cycle flag |
| clr_cmp_i | input | 1 | Clear strobe for the match flag |
| count_o | output | 8 | Current count |
| pwm_o | output | 1 | PWM pin |
| ovf_o | output | 1 | Sticky end-of-cycle flag |
| cmp_o | output | 1 | Sticky match flag |

## Verification
The bench sweeps compare values across the full range, in both polarities, through complete dual-slope periods. A design that mishandled the extremes would emit a one-tick sliver of the wrong level at the turning points, at 0 or at 255. The bench also writes a new compare value in the middle of a period. A design without buffering would change the pin before the top of the count and cut a pulse short. The remaining targets are the timing of the divider at every ratio, the rollover edge of the flag, and a clear strobe that lands on the same cycle as a set event. Designs that get these wrong drift by whole divider periods, raise the flag one tick early or late, or lose the event altogether.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    // Width of the free-running divider, set by the largest ratio (1024).
    localparam int PS_W = 10;

    typedef enum logic [2:0] {
        PS_DIV1    = 3'd0,
        PS_DIV8    = 3'd1,
        PS_DIV64   = 3'd2,
        PS_DIV256  = 3'd3,
        PS_DIV1024 = 3'd4
    } ps_sel_e;

    typedef enum logic {
        MODE_WRAP = 1'b0,
        MODE_DUAL = 1'b1
    } cnt_mode_e;

    // Single-cycle events raised by the counter toward the flag logic.
    typedef struct packed {
        logic ovf;
        logic cmp;
    } tmr_evt_t;

    // Low bits of the divider that must all be one for an enable pulse.
    function automatic logic [PS_W-1:0] ps_mask(input logic [2:0] sel);
        case (sel)
            PS_DIV1:   return 10'd0;
            PS_DIV8:   return 10'd7;
            PS_DIV64:  return 10'd63;
            PS_DIV256: return 10'd255;
            default:   return 10'd1023;
        endcase
    endfunction

endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler
    import pwmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] sel_i,
    output logic       tick_o
);

    logic [PS_W-1:0] div_q;
    logic [PS_W-1:0] mask;

    assign mask = ps_mask(sel_i);

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    // One pulse every 2^k cycles: all masked bits high.
    assign tick_o = ((div_q & mask) == mask);

endmodule

// File: rtl/pwmt_count.sv
module pwmt_count
    import pwmt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic         mode_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] nxt_cnt_o,
    output logic         nxt_down_o,
    output logic [W-1:0] nxt_ocr_o,
    output tmr_evt_t     evt_o
);

    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q;
    logic [W-1:0] ocr_q;
    logic [W-1:0] buf_q;
    logic [W-1:0] buf_d;
    logic         down_q;
    logic         rising;
    logic         hit_top;

    always_comb begin
        nxt_cnt_o  = cnt_q;
        nxt_down_o = down_q;
        evt_o      = '0;
        rising     = 1'b0;
        buf_d      = wr_en_i ? wr_data_i : buf_q;
        if (tick_i) begin
            if (mode_i == MODE_WRAP) begin
                nxt_cnt_o  = cnt_q + ONE;
                nxt_down_o = 1'b0;
                evt_o.ovf  = (cnt_q == TOP);
            end else begin
                // Climb from zero, or keep climbing below the top.
                rising = (cnt_q == '0) || (!down_q && (cnt_q != TOP));
                if (rising) begin
                    nxt_cnt_o  = cnt_q + ONE;
                    nxt_down_o = ((cnt_q + ONE) == TOP);
                end else begin
                    nxt_cnt_o  = cnt_q - ONE;
                    nxt_down_o = (cnt_q != ONE);
                    evt_o.ovf  = (cnt_q == ONE);
                end
            end
        end
        hit_top = tick_i && (nxt_cnt_o == TOP);
        // Wrap mode writes through; dual-slope reloads at the top only.
        if (mode_i == MODE_WRAP) nxt_ocr_o = wr_en_i ? wr_data_i : ocr_q;
        else                     nxt_ocr_o = hit_top ? buf_d : ocr_q;
        evt_o.cmp = tick_i && (nxt_cnt_o == nxt_ocr_o);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
            ocr_q  <= '0;
            buf_q  <= '0;
        end else begin
            cnt_q  <= nxt_cnt_o;
            down_q <= nxt_down_o;
            ocr_q  <= nxt_ocr_o;
            buf_q  <= buf_d;
        end
    end

    assign cnt_o = cnt_q;

    assert_hold_no_tick_R1: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(cnt_q));

    assert_wrap_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tick_i && mode_i == MODE_WRAP) |=> (cnt_q == $past(cnt_q) + ONE));

    assert_dual_step_R4: assert property (@(posedge clk) disable iff (rst)
        (tick_i && mode_i == MODE_DUAL) |=>
            ((cnt_q == $past(cnt_q) + ONE) || (cnt_q == $past(cnt_q) - ONE)));

    assert_dual_turn_R4: assert property (@(posedge clk) disable iff (rst)
        (tick_i && mode_i == MODE_DUAL && cnt_q == TOP) |=> (cnt_q == TOP - ONE));

endmodule

// File: rtl/pwmt_wave.sv
module pwmt_wave
    import pwmt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic         mode_i,
    input  logic         inv_i,
    input  logic [W-1:0] nxt_cnt_i,
    input  logic         nxt_down_i,
    input  logic [W-1:0] nxt_ocr_i,
    input  tmr_evt_t     evt_i,
    input  logic         clr_ovf_i,
    input  logic         clr_cmp_i,
    output logic         pwm_o,
    output logic         ovf_o,
    output logic         cmp_o
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic raw_q;
    logic ovf_q;
    logic cmp_q;

    // Non-inverted level for a given count state and compare value.
    function automatic logic dual_level(input logic [W-1:0] c,
                                        input logic         dn,
                                        input logic [W-1:0] r);
        if (r == '0)            return 1'b0;
        if (r == TOP)           return 1'b1;
        if (!dn || (c == TOP))  return (c < r);
        return (c <= r);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= 1'b0;
            ovf_q <= 1'b0;
            cmp_q <= 1'b0;
        end else begin
            if (tick_i)
                raw_q <= (mode_i == MODE_DUAL) && dual_level(nxt_cnt_i, nxt_down_i, nxt_ocr_i);
            ovf_q <= evt_i.ovf | (ovf_q & ~clr_ovf_i);
            cmp_q <= evt_i.cmp | (cmp_q & ~clr_cmp_i);
        end
    end

    assign pwm_o = (mode_i == MODE_DUAL) ? (raw_q ^ inv_i) : 1'b0;
    assign ovf_o = ovf_q;
    assign cmp_o = cmp_q;

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !clr_ovf_i) |=> ovf_q);

    assert_cmp_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (cmp_q && !clr_cmp_i) |=> cmp_q);

    assert_ovf_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_ovf_i && !evt_i.ovf) |=> !ovf_q);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (evt_i.cmp && clr_cmp_i) |=> cmp_q);

    assert_floor_low_R9: assert property (@(posedge clk) disable iff (rst)
        (tick_i && mode_i == MODE_DUAL && nxt_ocr_i == '0) |=> !raw_q);

endmodule

// File: rtl/pwmt_timer.sv
module pwmt_timer
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       ps_sel_i,
    input  logic             mode_i,
    input  logic             inv_i,
    input  logic             cmp_wr_i,
    input  logic [CNT_W-1:0] cmp_data_i,
    input  logic             clr_ovf_i,
    input  logic             clr_cmp_i,
    output logic [CNT_W-1:0] count_o,
    output logic             pwm_o,
    output logic             ovf_o,
    output logic             cmp_o
);

    logic             tick;
    logic [CNT_W-1:0] nxt_cnt;
    logic             nxt_down;
    logic [CNT_W-1:0] nxt_ocr;
    tmr_evt_t         evt;

    pwmt_prescaler u_div (
        .clk    (clk),
        .rst    (rst),
        .sel_i  (ps_sel_i),
        .tick_o (tick)
    );

    pwmt_count #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .mode_i     (mode_i),
        .wr_en_i    (cmp_wr_i),
        .wr_data_i  (cmp_data_i),
        .cnt_o      (count_o),
        .nxt_cnt_o  (nxt_cnt),
        .nxt_down_o (nxt_down),
        .nxt_ocr_o  (nxt_ocr),
        .evt_o      (evt)
    );

    pwmt_wave #(.W(CNT_W)) u_wave (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .mode_i     (mode_i),
        .inv_i      (inv_i),
        .nxt_cnt_i  (nxt_cnt),
        .nxt_down_i (nxt_down),
        .nxt_ocr_i  (nxt_ocr),
        .evt_i      (evt),
        .clr_ovf_i  (clr_ovf_i),
        .clr_cmp_i  (clr_cmp_i),
        .pwm_o      (pwm_o),
        .ovf_o      (ovf_o),
        .cmp_o      (cmp_o)
    );

endmodule

// File: tb/pwmt_timer_bench.sv
module pwmt_timer_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] ps_sel = 3'd0;
    logic       mode = 1'b0;
    logic       inv = 1'b0;
    logic       cmp_wr = 1'b0;
    logic [7:0] cmp_data = 8'd0;
    logic       clr_ovf = 1'b0;
    logic       clr_cmp = 1'b0;
    logic [7:0] count;
    logic       pwm;
    logic       ovf;
    logic       cmp;

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    string focus = "";

    // Bench-side reference state
    int m_pre, m_cnt, m_ocr, m_buf;
    bit m_dn, m_ovf, m_cmp;

    pwmt_timer u_pwmt_timer (
        .clk(clk), .rst(rst), .ps_sel_i(ps_sel), .mode_i(mode), .inv_i(inv),
        .cmp_wr_i(cmp_wr), .cmp_data_i(cmp_data), .clr_ovf_i(clr_ovf),
        .clr_cmp_i(clr_cmp), .count_o(count), .pwm_o(pwm), .ovf_o(ovf), .cmp_o(cmp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ratio(input int sel);
        case (sel)
            0: return 1;
            1: return 8;
            2: return 64;
            3: return 256;
            default: return 1024;
        endcase
    endfunction

    function automatic int exp_pin();
        int lvl;
        if (!mode) return 0;
        if (m_ocr == 0)        lvl = 0;
        else if (m_ocr == 255) lvl = 1;
        else if (!m_dn || m_cnt == 255) lvl = (m_cnt < m_ocr) ? 1 : 0;
        else                   lvl = (m_cnt <= m_ocr) ? 1 : 0;
        return inv ? 1 - lvl : lvl;
    endfunction

    task automatic model_reset();
        m_pre = 0; m_cnt = 0; m_ocr = 0; m_buf = 0;
        m_dn = 0; m_ovf = 0; m_cmp = 0;
    endtask

    task automatic model_edge();
        int n, ncnt, nbuf, nocr;
        bit tick, ndn, ovs, cms;
        n = ratio(int'(ps_sel));
        tick = ((m_pre % n) == n - 1);
        m_pre = (m_pre + 1) % 1024;
        nbuf = cmp_wr ? int'(cmp_data) : m_buf;
        ncnt = m_cnt; ndn = m_dn; ovs = 0;
        if (tick) begin
            if (!mode) begin
                ncnt = (m_cnt + 1) % 256; ndn = 0; ovs = (m_cnt == 255);
            end else if (m_cnt == 0 || (!m_dn && m_cnt != 255)) begin
                ncnt = m_cnt + 1; ndn = (ncnt == 255);
            end else begin
                ncnt = m_cnt - 1; ndn = (ncnt != 0); ovs = (ncnt == 0);
            end
        end
        if (!mode) nocr = cmp_wr ? int'(cmp_data) : m_ocr;
        else       nocr = (tick && ncnt == 255) ? nbuf : m_ocr;
        cms = tick && (ncnt == nocr);
        m_ovf = ovs | (m_ovf & !clr_ovf);
        m_cmp = cms | (m_cmp & !clr_cmp);
        m_cnt = ncnt; m_dn = ndn; m_ocr = nocr; m_buf = nbuf;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        string tc, to, tp;
        tc = (ps_sel != 3'd0) ? "R1 count" : (mode ? "R4 count" : "R2 count");
        to = mode ? "R5 ovf flag" : "R3 ovf flag";
        if (!mode)                        tp = "R12 pin";
        else if (inv)                     tp = "R10 pin";
        else if (m_ocr == 0 || m_ocr == 255) tp = "R9 pin";
        else                              tp = "R8 pin";
        if (focus != "") begin
            tc = {focus, " count"}; to = {focus, " ovf flag"}; tp = {focus, " pin"};
        end
        chk(tc, int'(count), m_cnt);
        chk(to, int'(ovf), int'(m_ovf));
        chk((focus != "") ? {focus, " cmp flag"} : "R6 cmp flag", int'(cmp), int'(m_cmp));
        chk(tp, int'(pwm), exp_pin());
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            check_all();
        end
    endtask

    task automatic do_reset(input bit md, input bit iv, input logic [2:0] ps);
        @(negedge clk);
        mode = md; inv = iv; ps_sel = ps;
        cmp_wr = 0; clr_ovf = 0; clr_cmp = 0; rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        model_reset();
        chk("R13 reset count", int'(count), 0);
        chk("R13 reset ovf", int'(ovf), 0);
        chk("R13 reset cmp", int'(cmp), 0);
        chk("R13 reset pin", int'(pwm), (md && iv) ? 1 : 0);
    endtask

    task automatic write_cmp(input int v);
        cmp_wr = 1; cmp_data = 8'(v);
        run(1);
        cmp_wr = 0;
    endtask

    initial begin
        // Wrap mode, no division: rollover and flag timing
        do_reset(0, 0, 3'd0);
        run(600);
        focus = "R7";
        clr_ovf = 1; clr_cmp = 1; run(1);
        clr_ovf = 0; clr_cmp = 0; run(2);
        for (int k = 0; k < 300 && count != 8'd255; k++) run(1);
        clr_ovf = 1; run(1);       // clear on the rollover cycle: set wins
        clr_ovf = 0; run(3);
        focus = "R11";
        write_cmp(100);            // wrap mode: immediate
        run(300);
        focus = "R7";
        for (int k = 0; k < 300 && count != 8'd99; k++) run(1);
        clr_cmp = 1; run(1);       // match on this edge, clear loses
        clr_cmp = 0; run(3);
        focus = "";

        // Divider ratios in wrap mode
        do_reset(0, 0, 3'd1); run(2100);
        do_reset(0, 0, 3'd2); run(200);
        do_reset(0, 1, 3'd3); run(600);
        do_reset(0, 0, 3'd4); run(2100);
        do_reset(0, 0, 3'd7); run(1100);

        // Dual-slope sweep over compare values and both polarities
        for (int v = 0; v <= 255; v += 5) begin
            for (int iv = 0; iv < 2; iv++) begin
                do_reset(1, iv[0], 3'd0);
                write_cmp(v);
                run(800);
            end
        end
        for (int iv = 0; iv < 2; iv++) begin
            do_reset(1, iv[0], 3'd0); write_cmp(1);   run(800);
            do_reset(1, iv[0], 3'd0); write_cmp(254); run(800);
        end

        // Dual-slope with division by 8, one full period after reload
        do_reset(1, 0, 3'd1);
        write_cmp(77);
        run(6200);

        // Buffered compare: mid-period write must wait for the top
        do_reset(1, 0, 3'd0);
        focus = "R11";
        write_cmp(200);
        run(400);
        write_cmp(20);
        run(700);

        // Clear strobes held during dual-slope events
        focus = "R7";
        clr_cmp = 1; clr_ovf = 1; run(300);
        clr_cmp = 0; clr_ovf = 0; run(300);
        focus = "";

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule